// File: doc/BRIEF.md
# SATA Host Port Command Slot Tracker

This block keeps the per-port command bookkeeping of a SATA host adapter. It holds one command-issue bit and one queued-active bit for each command slot, and it tracks the last device status byte. The link side hands it simplified received-frame events. A register event carries device status for one slot. A set-device-bits event carries status and a mask of finished queued slots. From these events the block decides which slot bits to release and which interrupt status bits to raise.

A device error freezes the slot bits and puts the port into a fatal state. In that state it raises the task-file error interrupt in place of any normal completion interrupt. Software works through a small register port and recovers the port by clearing the start bit.

Register addresses (3-bit `reg_addr`): 0 issue, 1 active, 2 control (bit 0 start, read/write; bit 1 fatal, read-only), 3 interrupt status, 4 interrupt enable, 5 error flags, 6 task-file status (read-only). Address 7 reads as zero. Interrupt status bits are: bit 0 register-event done, bit 1 set-device-bits done, bit 2 task-file error. Status byte bits are: bit 0 error, bit 3 data request, bit 7 busy. `evt_kind` is 0 for a register event and 1 for a set-device-bits event.

Top module: `sata_slot_tracker`

## Requirements
- R1: After synchronous reset every readable register reads zero and `irq` is low.
- R2: A write to issue (address 0) or active (address 1) ORs in the 1 bits of the data, only while start is 1 and the port is not fatal; 0 bits never clear anything, and writes at other times have no effect.
- R3: An accepted register event whose status has error (bit 0), data request (bit 3) and busy (bit 7) all zero clears the issue bit of `evt_slot`, and sets interrupt status bit 0 only when `evt_irq` is 1.
- R4: An accepted register event with busy or data request set changes no slot bit and raises no interrupt status bit.
- R5: An accepted event of either kind with status bit 0 set leaves issue and active unchanged, sets control bit 1 (fatal) and sets interrupt status bit 2 whatever `evt_irq` is, and sets neither interrupt status bit 0 nor bit 1.
- R6: An accepted set-device-bits event without error clears the active bits named in `evt_mask`, and sets interrupt status bit 1 only when `evt_irq` is 1.
- R7: Writing control with start going from 1 to 0 clears issue, active and the fatal flag on the next cycle.
- R8: A pulse on `comreset` leaves issue and active unchanged and clears the task-file status to zero.
- R9: Interrupt status bits are cleared by writing 1 to them at address 3, and `irq` equals the OR of status ANDed with enable, updating in the same cycle as the status register.
- R10: The error register holds fixed-meaning flags: bit 0 is set when an error event is taken, bit 1 when an event arrives while fatal; no slot number or other value is ever placed in it, and writing 1 clears a flag.
- R11: While the port is fatal, or start is 0, events change no slot bit, interrupt status bit or task-file status.
- R12: The task-file status register holds the status byte of the last accepted event.
- R13: `reg_rdata` presents the register selected by `reg_addr` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | NUM_SLOTS | Register write data |
| reg_rdata | output | NUM_SLOTS | Registered read data |
| evt_valid | input | 1 | Received event strobe |
| evt_kind | input | 1 | 0 register event, 1 set-device-bits event |
| evt_sts | input | STS_W | Device status byte carried by the event |
| evt_irq | input | 1 | Interrupt-request flag carried by the event |
| evt_slot | input | log2(NUM_SLOTS) | Slot that a register event refers to |
| evt_mask | input | NUM_SLOTS | Finished queued slots of a set-device-bits event |
| comreset | input | 1 | Port reset pulse from the link side |
| irq | output | 1 | Port interrupt |

## Verification
The bench aims at the error path. There it checks that an error status with the interrupt flag clear still raises the task-file error, while the issue bits stay put. A design that released the slot or gated the error interrupt on the flag would show a cleared issue bit or a silent port. It checks that a port reset leaves the active bits alone, and that only a start 1-to-0 write recovers the port. A design that wiped them early would lose queued commands, and one that recovered early would accept events while frozen. It also reads back the error register after an error on a non-zero slot. A design that stored the slot number there would read back a value other than the single flag bit.

// File: rtl/sata_slot_pkg.sv
package sata_slot_pkg;

  typedef enum logic [2:0] {
    A_ISSUE  = 3'd0,
    A_ACTIVE = 3'd1,
    A_CTRL   = 3'd2,
    A_ISTAT  = 3'd3,
    A_IEN    = 3'd4,
    A_ERR    = 3'd5,
    A_TFSTAT = 3'd6
  } reg_addr_e;

  localparam int ST_ERR  = 0;
  localparam int ST_DRQ  = 3;
  localparam int ST_BSY  = 7;

  localparam int ISTAT_W = 3;
  localparam int IS_RDONE = 0;
  localparam int IS_SDB   = 1;
  localparam int IS_TFE   = 2;

  localparam int ERR_W     = 2;
  localparam int ER_DEVERR = 0;
  localparam int ER_DROP   = 1;

  localparam logic EV_REG = 1'b0;
  localparam logic EV_SDB = 1'b1;

  typedef struct packed {
    logic go_fatal;
    logic set_rdone;
    logic set_sdb;
    logic drop;
    logic tf_load;
  } evt_act_t;

endpackage

// File: rtl/slot_evt_decode.sv
module slot_evt_decode
  import sata_slot_pkg::*;
#(
  parameter int NUM_SLOTS = 32
) (
  input  logic                         evt_valid,
  input  logic                         evt_kind,
  input  logic                         sts_err,
  input  logic                         sts_bsy,
  input  logic                         sts_drq,
  input  logic                         evt_irq,
  input  logic [$clog2(NUM_SLOTS)-1:0] evt_slot,
  input  logic [NUM_SLOTS-1:0]         evt_mask,
  input  logic                         running,
  input  logic                         fatal,
  output logic [NUM_SLOTS-1:0]         ci_clr,
  output logic [NUM_SLOTS-1:0]         sact_clr,
  output evt_act_t                     act
);
  localparam logic [NUM_SLOTS-1:0] ONE = NUM_SLOTS'(1);

  logic accept;
  assign accept = evt_valid & running;

  always_comb begin
    ci_clr   = '0;
    sact_clr = '0;
    act      = '0;
    act.drop = evt_valid & fatal;
    if (accept) begin
      act.tf_load = 1'b1;
      if (sts_err) begin
        act.go_fatal = 1'b1;
      end else if (evt_kind == EV_REG) begin
        if (!sts_bsy && !sts_drq) begin
          ci_clr        = ONE << evt_slot;
          act.set_rdone = evt_irq;
        end
      end else begin
        sact_clr    = evt_mask;
        act.set_sdb = evt_irq;
      end
    end
  end
endmodule

// File: rtl/slot_bank.sv
module slot_bank #(
  parameter int NUM_SLOTS = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wipe,
  input  logic [NUM_SLOTS-1:0] set_mask,
  input  logic [NUM_SLOTS-1:0] clr_mask,
  output logic [NUM_SLOTS-1:0] bits
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || wipe)      bits[g] <= 1'b0;
      else if (set_mask[g]) bits[g] <= 1'b1;
      else if (clr_mask[g]) bits[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/slot_irq_unit.sv
module slot_irq_unit #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] w1c_vec,
  input  logic         ien_we,
  input  logic [W-1:0] ien_wdata,
  output logic [W-1:0] istat,
  output logic [W-1:0] ien,
  output logic         irq
);
  logic [W-1:0] istat_n, ien_n;

  assign istat_n = (istat & ~w1c_vec) | set_vec;
  assign ien_n   = ien_we ? ien_wdata : ien;

  always_ff @(posedge clk) begin
    if (rst) begin
      istat <= '0;
      ien   <= '0;
      irq   <= 1'b0;
    end else begin
      istat <= istat_n;
      ien   <= ien_n;
      irq   <= |(istat_n & ien_n);
    end
  end
endmodule

// File: rtl/sata_slot_tracker.sv
module sata_slot_tracker
  import sata_slot_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int STS_W     = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         reg_wr,
  input  logic [2:0]                   reg_addr,
  input  logic [NUM_SLOTS-1:0]         reg_wdata,
  output logic [NUM_SLOTS-1:0]         reg_rdata,
  input  logic                         evt_valid,
  input  logic                         evt_kind,
  input  logic [STS_W-1:0]             evt_sts,
  input  logic                         evt_irq,
  input  logic [$clog2(NUM_SLOTS)-1:0] evt_slot,
  input  logic [NUM_SLOTS-1:0]         evt_mask,
  input  logic                         comreset,
  output logic                         irq
);
  logic                 start_q, fatal_q;
  logic [ERR_W-1:0]     errreg_q;
  logic [STS_W-1:0]     tfstat_q;
  logic [NUM_SLOTS-1:0] ci_q, sact_q;
  logic [NUM_SLOTS-1:0] ci_clr, sact_clr, ci_set, sact_set;
  logic [ISTAT_W-1:0]   istat_q, ien_q, istat_set, istat_w1c;
  logic [ERR_W-1:0]     err_w1c;
  evt_act_t             act;
  logic                 running, stop;
  logic                 wr_issue, wr_active, wr_ctrl, wr_istat, wr_ien, wr_err;

  assign running   = start_q & ~fatal_q;
  assign wr_issue  = reg_wr && (reg_addr == A_ISSUE);
  assign wr_active = reg_wr && (reg_addr == A_ACTIVE);
  assign wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
  assign wr_istat  = reg_wr && (reg_addr == A_ISTAT);
  assign wr_ien    = reg_wr && (reg_addr == A_IEN);
  assign wr_err    = reg_wr && (reg_addr == A_ERR);
  assign stop      = wr_ctrl && start_q && !reg_wdata[0];

  assign ci_set    = (wr_issue  && running) ? reg_wdata : '0;
  assign sact_set  = (wr_active && running) ? reg_wdata : '0;
  assign istat_w1c = wr_istat ? reg_wdata[ISTAT_W-1:0] : '0;
  assign err_w1c   = wr_err   ? reg_wdata[ERR_W-1:0]   : '0;

  always_comb begin
    istat_set           = '0;
    istat_set[IS_RDONE] = act.set_rdone;
    istat_set[IS_SDB]   = act.set_sdb;
    istat_set[IS_TFE]   = act.go_fatal;
  end

  slot_evt_decode #(.NUM_SLOTS(NUM_SLOTS)) u_dec (
    .evt_valid (evt_valid),
    .evt_kind  (evt_kind),
    .sts_err   (evt_sts[ST_ERR]),
    .sts_bsy   (evt_sts[ST_BSY]),
    .sts_drq   (evt_sts[ST_DRQ]),
    .evt_irq   (evt_irq),
    .evt_slot  (evt_slot),
    .evt_mask  (evt_mask),
    .running   (running),
    .fatal     (fatal_q),
    .ci_clr    (ci_clr),
    .sact_clr  (sact_clr),
    .act       (act)
  );

  slot_bank #(.NUM_SLOTS(NUM_SLOTS)) u_issue (
    .clk(clk), .rst(rst), .wipe(stop),
    .set_mask(ci_set), .clr_mask(ci_clr), .bits(ci_q)
  );

  slot_bank #(.NUM_SLOTS(NUM_SLOTS)) u_active (
    .clk(clk), .rst(rst), .wipe(stop),
    .set_mask(sact_set), .clr_mask(sact_clr), .bits(sact_q)
  );

  slot_irq_unit #(.W(ISTAT_W)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .set_vec   (istat_set),
    .w1c_vec   (istat_w1c),
    .ien_we    (wr_ien),
    .ien_wdata (reg_wdata[ISTAT_W-1:0]),
    .istat     (istat_q),
    .ien       (ien_q),
    .irq       (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q  <= 1'b0;
      fatal_q  <= 1'b0;
      errreg_q <= '0;
      tfstat_q <= '0;
    end else begin
      if (wr_ctrl) start_q <= reg_wdata[0];
      if (stop)              fatal_q <= 1'b0;
      else if (act.go_fatal) fatal_q <= 1'b1;
      errreg_q[ER_DEVERR] <= (errreg_q[ER_DEVERR] & ~err_w1c[ER_DEVERR]) | act.go_fatal;
      errreg_q[ER_DROP]   <= (errreg_q[ER_DROP]   & ~err_w1c[ER_DROP])   | act.drop;
      if (comreset)         tfstat_q <= '0;
      else if (act.tf_load) tfstat_q <= evt_sts;
    end
  end

  logic [NUM_SLOTS-1:0] rd_n;
  always_comb begin
    rd_n = '0;
    case (reg_addr)
      A_ISSUE:  rd_n = ci_q;
      A_ACTIVE: rd_n = sact_q;
      A_CTRL:   rd_n[1:0] = {fatal_q, start_q};
      A_ISTAT:  rd_n[ISTAT_W-1:0] = istat_q;
      A_IEN:    rd_n[ISTAT_W-1:0] = ien_q;
      A_ERR:    rd_n[ERR_W-1:0] = errreg_q;
      A_TFSTAT: rd_n[STS_W-1:0] = tfstat_q;
      default:  rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_n;
  end
endmodule

// File: rtl/slot_tracker_checker.sv
module slot_tracker_checker #(
  parameter int NUM_SLOTS = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 reg_wr,
  input logic [2:0]           reg_addr,
  input logic                 wd0,
  input logic                 evt_valid,
  input logic                 sts_err,
  input logic                 comreset,
  input logic                 start,
  input logic                 fatal,
  input logic [NUM_SLOTS-1:0] ci,
  input logic [NUM_SLOTS-1:0] sact,
  input logic [2:0]           istat,
  input logic [2:0]           ien,
  input logic [1:0]           errreg,
  input logic                 irq
);
  p_issue_gate_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 3'd0 && !(start && !fatal) && !evt_valid) |=> (ci == $past(ci)));

  p_err_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    (start && !fatal && evt_valid && sts_err && !reg_wr)
      |=> (ci == $past(ci) && sact == $past(sact) && fatal && istat[2]));

  p_err_no_normal_r5: assert property (@(posedge clk) disable iff (rst)
    (start && !fatal && evt_valid && sts_err && !reg_wr)
      |=> (istat[1:0] == $past(istat[1:0])));

  p_stop_wipe_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 3'd2 && start && !wd0) |=> (ci == '0 && sact == '0 && !fatal));

  p_comreset_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (comreset && !reg_wr && !evt_valid) |=> (ci == $past(ci) && sact == $past(sact)));

  p_irq_mask_r9: assert property (@(posedge clk) disable iff (rst)
    irq == |(istat & ien));

  p_deverr_cause_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(errreg[0]) |-> $past(evt_valid && sts_err));

  p_drop_cause_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(errreg[1]) |-> $past(evt_valid && fatal));

  p_fatal_freeze_r11: assert property (@(posedge clk) disable iff (rst)
    (fatal && evt_valid && !reg_wr) |=> (ci == $past(ci) && sact == $past(sact)));
endmodule

bind sata_slot_tracker slot_tracker_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .wd0(reg_wdata[0]),
  .evt_valid(evt_valid), .sts_err(evt_sts[0]), .comreset(comreset),
  .start(start_q), .fatal(fatal_q), .ci(ci_q), .sact(sact_q),
  .istat(istat_q), .ien(ien_q), .errreg(errreg_q), .irq(irq)
);

// File: tb/sim_sata_slot_tracker.sv
`timescale 1ns/100ps
module sim_sata_slot_tracker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        evt_valid = 1'b0, evt_kind = 1'b0, evt_irq = 1'b0;
  logic [7:0]  evt_sts = '0;
  logic [4:0]  evt_slot = '0;
  logic [31:0] evt_mask = '0;
  logic        comreset = 1'b0;
  logic        irq;

  always #2.5 clk = ~clk;

  sata_slot_tracker u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_valid(evt_valid),
    .evt_kind(evt_kind), .evt_sts(evt_sts), .evt_irq(evt_irq),
    .evt_slot(evt_slot), .evt_mask(evt_mask), .comreset(comreset), .irq(irq)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  // behavioural reference model
  bit [31:0] m_ci, m_sa, m_rd;
  bit        m_start, m_fatal, m_irq;
  bit [2:0]  m_is, m_ie;
  bit [1:0]  m_er;
  bit [7:0]  m_tf;

  function automatic bit [31:0] peek(input bit [2:0] a);
    case (a)
      3'd0: return m_ci;
      3'd1: return m_sa;
      3'd2: return {30'd0, m_fatal, m_start};
      3'd3: return {29'd0, m_is};
      3'd4: return {29'd0, m_ie};
      3'd5: return {30'd0, m_er};
      3'd6: return {24'd0, m_tf};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ci = 0; m_sa = 0; m_rd = 0; m_start = 0; m_fatal = 0; m_irq = 0;
      m_is = 0; m_ie = 0; m_er = 0; m_tf = 0;
    end else begin
      bit [31:0] nci, nsa;
      bit [2:0]  nis;
      bit        nfatal, go;
      m_rd = peek(reg_addr);
      nci = m_ci; nsa = m_sa; nis = m_is; nfatal = m_fatal; go = 0;
      if (reg_wr && reg_addr == 3'd3) nis = nis & ~reg_wdata[2:0];
      if (reg_wr && reg_addr == 3'd5) m_er = m_er & ~reg_wdata[1:0];
      if (evt_valid && m_fatal) m_er[1] = 1;
      if (evt_valid && m_start && !m_fatal) begin
        m_tf = evt_sts;
        if (evt_sts[0]) begin
          go = 1; nfatal = 1; nis[2] = 1; m_er[0] = 1;
        end else if (!evt_kind) begin
          if (!evt_sts[7] && !evt_sts[3]) begin
            nci[evt_slot] = 0;
            if (evt_irq) nis[0] = 1;
          end
        end else begin
          nsa = nsa & ~evt_mask;
          if (evt_irq) nis[1] = 1;
        end
      end
      if (comreset) m_tf = 0;
      if (reg_wr && m_start && !m_fatal) begin
        if (reg_addr == 3'd0) nci = nci | reg_wdata;
        if (reg_addr == 3'd1) nsa = nsa | reg_wdata;
      end
      if (reg_wr && reg_addr == 3'd4) m_ie = reg_wdata[2:0];
      if (reg_wr && reg_addr == 3'd2) begin
        if (m_start && !reg_wdata[0]) begin
          nci = 0; nsa = 0; nfatal = 0;
        end
        m_start = reg_wdata[0];
      end
      m_ci = nci; m_sa = nsa; m_is = nis; m_fatal = nfatal;
      m_irq = |(m_is & m_ie);
      if (go) m_fatal = nfatal;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      n_tests++;
      if (reg_rdata !== m_rd) begin
        n_fail++;
        $display("FAIL R13 model read: actual %h expected %h", reg_rdata, m_rd);
      end
      n_tests++;
      if (irq !== m_irq) begin
        n_fail++;
        $display("FAIL R9 model irq: actual %b expected %b", irq, m_irq);
      end
    end
  end

  task automatic chk(input string tag, input bit [31:0] got, input bit [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input bit [2:0] a, input bit [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic ev(input bit k, input bit [7:0] s, input bit i,
                    input bit [4:0] sl, input bit [31:0] m);
    evt_valid = 1; evt_kind = k; evt_sts = s; evt_irq = i; evt_slot = sl; evt_mask = m;
    @(negedge clk);
    evt_valid = 0; evt_kind = 0; evt_sts = 0; evt_irq = 0; evt_slot = 0; evt_mask = 0;
  endtask

  task automatic rd(input bit [2:0] a, output bit [31:0] v);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic summary();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    bit [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v); chk("R1 reset value", v, 0);
    end
    chk("R1 irq low", irq, 0);

    wr(0, 32'hF); rd(0, v); chk("R2 write while stopped", v, 0);
    wr(2, 1);
    wr(0, 32'hF0); wr(0, 32'h1); rd(0, v); chk("R2 zero bits keep", v, 32'hF1);
    wr(4, 7);

    ev(0, 8'h80, 1, 4, 0); rd(0, v); chk("R4 busy keeps issue", v, 32'hF1);
    ev(0, 8'h08, 1, 4, 0); rd(3, v); chk("R4 drq no interrupt", v, 0);

    ev(0, 8'h40, 1, 4, 0); rd(0, v); chk("R3 clean clears slot", v, 32'hE1);
    rd(3, v); chk("R3 done bit", v, 1);
    chk("R9 irq raised", irq, 1);
    rd(6, v); chk("R12 task-file status", v, 32'h40);
    wr(3, 1); chk("R9 w1c drops irq", irq, 0);
    rd(3, v); chk("R9 w1c status", v, 0);

    ev(0, 8'h50, 0, 0, 0); rd(0, v); chk("R3 slot0 cleared", v, 32'hE0);
    rd(3, v); chk("R3 no flag no irq", v, 0);

    wr(1, 32'h300); rd(1, v); chk("R2 active set", v, 32'h300);
    ev(1, 8'h40, 1, 0, 32'h100); rd(1, v); chk("R6 mask clears active", v, 32'h200);
    rd(3, v); chk("R6 sdb bit", v, 2);
    wr(4, 1); chk("R9 enable masks irq", irq, 0);
    wr(4, 7); chk("R9 enable passes irq", irq, 1);
    wr(3, 2);

    ev(0, 8'h41, 0, 5, 0); rd(0, v); chk("R5 issue frozen", v, 32'hE0);
    rd(1, v); chk("R5 active frozen", v, 32'h200);
    rd(3, v); chk("R5 only tfe", v, 4);
    rd(2, v); chk("R5 fatal flag", v, 3);
    rd(5, v); chk("R10 error flag not tag", v, 1);
    rd(6, v); chk("R12 error status", v, 32'h41);

    ev(0, 8'h40, 1, 5, 0); rd(0, v); chk("R11 event dropped", v, 32'hE0);
    rd(3, v); chk("R11 no new irq", v, 4);
    rd(5, v); chk("R10 drop flag", v, 3);
    wr(0, 1); rd(0, v); chk("R11 write ignored when fatal", v, 32'hE0);

    comreset = 1; @(negedge clk); comreset = 0;
    rd(0, v); chk("R8 issue kept", v, 32'hE0);
    rd(1, v); chk("R8 active kept", v, 32'h200);
    rd(6, v); chk("R8 status cleared", v, 0);

    wr(5, 3); rd(5, v); chk("R10 w1c", v, 0);
    wr(3, 4);
    wr(2, 0); rd(0, v); chk("R7 issue wiped", v, 0);
    rd(1, v); chk("R7 active wiped", v, 0);
    rd(2, v); chk("R7 fatal cleared", v, 0);

    wr(2, 1); wr(0, 32'h8000_0001); wr(1, 32'h8000_0000);
    ev(1, 8'h01, 1, 0, 32'h8000_0000); rd(1, v); chk("R5 sdb error keeps active", v, 32'h8000_0000);
    rd(3, v); chk("R5 sdb error tfe only", v, 4);
    rd(0, v); chk("R5 sdb error keeps issue", v, 32'h8000_0001);

    wr(2, 0); wr(3, 7); wr(5, 3);
    ev(0, 8'h40, 1, 31, 0); rd(3, v); chk("R11 stopped ignores", v, 0);
    rd(6, v); chk("R11 stopped status kept", v, 1);
    rd(7, v); chk("R13 unused address", v, 0);
    @(negedge clk);
    summary();
  end
endmodule